// File: doc/BRIEF.md
# I2C Message Transfer Sequencer

This block turns a short list of I2C messages into the byte-by-byte command stream that a byte-level I2C master engine needs. Each message descriptor holds a 7-bit target address, a read flag, a block-read flag and a length. A block read takes its real length from the first byte it receives. Software loads up to four descriptors and raises `go`. The sequencer then places the address byte on the engine's write port. After that, at every byte-complete event from the engine, it decides the next step: repeated start, read setup, byte read, byte write or stop. Each step sets the master, transmit-direction, no-acknowledge and repeated-start controls.

Every completion event is screened before any step is taken. The screen looks for an unfinished transfer, lost arbitration and a missing acknowledge where one was expected. The first fault found ends the transfer with a result code. A successful transfer ends with result 0. The bit-level SCL/SDA engine is outside this block. It is seen only through a write-data strobe, a data-read strobe and a completion event that carries the status flags and the received byte. Bytes to send come from the `tx_byte` input, which is selected by `tx_msg`/`tx_pos`. Received bytes leave on `rx_valid`/`rx_data`, tagged with their message and position.

Top module: `i2c_xfer_seq`

## Requirements
- R1: After reset, `busy`, `done` and all five control outputs are 0. A `go` sampled while idle makes `busy`, `ctl_en`, `ctl_master` and `ctl_tx` 1 and pulses `eng_wr_valid` with `eng_wr_data` = {address, read flag}, with the read flag in bit 0. A `go` sampled while busy has no effect.
- R2: Each message after the first starts, at the next event, with `ctl_rstart`, `ctl_master` and `ctl_tx` set and its address byte written.
- R3: In a write message, each event writes `tx_byte` for the current position. The address byte and every written byte expect an acknowledge. If `eng_rx_nak` is set on the event that answers them, the transfer ends with result 3.
- R4: At the first event of a read message with a non-zero length, `eng_rd_req` pulses (dummy read). `ctl_nak` is set only if the length is 1 and the message is not a block read.
- R5: While reading, `ctl_nak` is set when position = length-2 and `ctl_tx` is set when position = length-1. Otherwise both are clear. `eng_rx_nak` is ignored on read-byte events.
- R6: In a block read, a first byte of 0 or greater than 32 ends the transfer with result 4. Otherwise that byte is added to the length, and `ctl_nak` is set at once if the new length is 2.
- R7: The event status is checked in this order: `eng_complete` = 0 gives result 1, `eng_arb_lost` gives result 2, and a missing acknowledge gives result 3.
- R8: If the last message is a read, the transfer finishes on the event that delivers its final byte. If the last message is a write, the event after the final byte finishes with result 0.
- R9: Finishing pulses `done` for exactly one cycle, updates `result`, clears `busy` and leaves only `ctl_en` set among the control outputs.
- R10: Engine events that arrive while idle change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_we | input | 1 | Descriptor write strobe |
| desc_idx | input | 2 | Descriptor slot to write |
| desc_addr | input | 7 | Target address |
| desc_rd | input | 1 | Read message when 1 |
| desc_blk | input | 1 | Length extended by first received byte |
| desc_len | input | 8 | Message length in bytes |
| num_msgs | input | 3 | Messages in the transfer (1 to 4), sampled with `go` |
| go | input | 1 | Start strobe, accepted only while idle |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at finish |
| result | output | 3 | 0 ok, 1 unfinished, 2 arbitration lost, 3 no acknowledge, 4 bad block count |
| ctl_en | output | 1 | Engine enable |
| ctl_master | output | 1 | Master mode (start held) |
| ctl_tx | output | 1 | Transmit direction |
| ctl_nak | output | 1 | Send no-acknowledge on next received byte |
| ctl_rstart | output | 1 | Repeated start |
| eng_wr_valid | output | 1 | Write strobe for `eng_wr_data` |
| eng_wr_data | output | 8 | Address or data byte to send |
| eng_rd_req | output | 1 | Data-read strobe; launches next reception |
| eng_evt | input | 1 | Byte-complete event |
| eng_complete | input | 1 | Transfer-complete flag with the event |
| eng_arb_lost | input | 1 | Arbitration-lost flag with the event |
| eng_rx_nak | input | 1 | No acknowledge received |
| eng_rx_data | input | 8 | Byte received, valid with the event |
| tx_msg | output | 2 | Message index of the byte wanted on `tx_byte` |
| tx_pos | output | 9 | Byte position wanted on `tx_byte` |
| tx_byte | input | 8 | Byte to send, selected by `tx_msg`/`tx_pos` |
| rx_valid | output | 1 | Received byte strobe |
| rx_msg | output | 2 | Message index of received byte |
| rx_pos | output | 9 | Position of received byte |
| rx_data | output | 8 | Received byte |

## Verification
Every result is registered once. The response to `go` or to an engine event appears on the outputs one rising edge after the input is sampled: the address write, the data strobes, the control bits, `done` and `result` all land in that same cycle. The bench applies each stimulus for one cycle starting at a falling edge, removes it at the next falling edge, and compares all outputs at that point, which is half a period after the edge that updated them. The strobes `eng_wr_valid`, `eng_rd_req`, `rx_valid` and `done` are only one cycle wide, so they are caught in exactly that window.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

  typedef enum logic [2:0] {
    ACT_START    = 3'd0,
    ACT_RESTART  = 3'd1,
    ACT_RD_BEGIN = 3'd2,
    ACT_RD_BYTE  = 3'd3,
    ACT_WRITE    = 3'd4,
    ACT_STOP     = 3'd5
  } act_e;

  typedef enum logic [2:0] {
    RES_OK    = 3'd0,
    RES_IO    = 3'd1,
    RES_RETRY = 3'd2,
    RES_NODEV = 3'd3,
    RES_PROTO = 3'd4
  } res_e;

  typedef struct packed {
    logic en;
    logic master;
    logic tx;
    logic nak;
    logic rstart;
  } ctl_t;

  localparam ctl_t CTL_IDLE_EN = '{en: 1'b1, master: 1'b0, tx: 1'b0, nak: 1'b0, rstart: 1'b0};

endpackage

// File: rtl/i2c_seq_desc.sv
module i2c_seq_desc #(
  parameter int N  = 4,
  parameter int AW = 7,
  parameter int LW = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [AW-1:0] waddr,
  input  logic          wrd,
  input  logic          wblk,
  input  logic [LW-1:0] wlen,
  input  logic [IW-1:0] ridx,
  output logic [AW-1:0] raddr,
  output logic          rrd,
  output logic          rblk,
  output logic [LW-1:0] rlen
);

  logic [AW-1:0] addr_q [N];
  logic          rd_q   [N];
  logic          blk_q  [N];
  logic [LW-1:0] len_q  [N];

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic slot_en;
    assign slot_en = we && (widx == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q[g] <= '0;
        rd_q[g]   <= 1'b0;
        blk_q[g]  <= 1'b0;
        len_q[g]  <= '0;
      end else if (slot_en) begin
        addr_q[g] <= waddr;
        rd_q[g]   <= wrd;
        blk_q[g]  <= wblk;
        len_q[g]  <= wlen;
      end
    end
  end

  always_comb begin
    raddr = addr_q[ridx];
    rrd   = rd_q[ridx];
    rblk  = blk_q[ridx];
    rlen  = len_q[ridx];
  end

endmodule

// File: rtl/i2c_seq_evt_chk.sv
module i2c_seq_evt_chk
  import i2c_seq_pkg::*;
(
  input  logic complete,
  input  logic arb_lost,
  input  logic rx_nak,
  input  logic expect_ack,
  output logic fault,
  output res_e code
);

  always_comb begin
    fault = 1'b1;
    if (!complete)                  code = RES_IO;
    else if (arb_lost)              code = RES_RETRY;
    else if (expect_ack && rx_nak)  code = RES_NODEV;
    else begin
      code  = RES_OK;
      fault = 1'b0;
    end
  end

endmodule

// File: rtl/i2c_seq_core.sv
module i2c_seq_core
  import i2c_seq_pkg::*;
#(
  parameter int N       = 4,
  parameter int AW      = 7,
  parameter int LW      = 8,
  parameter int BLK_MAX = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int NW = $clog2(N + 1),
  localparam int PW = LW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [NW-1:0] num_msgs,
  input  logic [AW-1:0] d_addr,
  input  logic          d_rd,
  input  logic          d_blk,
  input  logic [LW-1:0] d_len,
  input  logic          evt,
  input  logic          fault,
  input  res_e          fault_code,
  input  logic [7:0]    rx_in,
  input  logic [7:0]    tx_byte,
  output logic [IW-1:0] cur_idx,
  output logic          expect_ack,
  output logic          busy,
  output logic          done,
  output logic [2:0]    result,
  output ctl_t          ctl,
  output logic          wr_valid,
  output logic [7:0]    wr_data,
  output logic          rd_req,
  output logic          rx_valid,
  output logic [IW-1:0] rx_msg,
  output logic [PW-1:0] rx_pos,
  output logic [7:0]    rx_data,
  output logic [PW-1:0] tx_pos
);

  logic          busy_q, busy_d;
  act_e          act_q, act_d;
  logic [IW-1:0] cur_q, cur_d;
  logic [PW-1:0] pos_q, pos_d;
  logic [PW-1:0] len_q, len_d;
  logic [NW-1:0] num_q, num_d;
  logic          exp_q, exp_d;
  ctl_t          ctl_q, ctl_d;
  res_e          res_q, res_d;
  logic          done_q, done_d;
  logic          wr_q, wr_d;
  logic [7:0]    wdat_q, wdat_d;
  logic          rd_q, rd_d;
  logic          rxv_q, rxv_d;
  logic [7:0]    rxd_q, rxd_d;
  logic [PW-1:0] rxp_q, rxp_d;
  logic [IW-1:0] rxm_q, rxm_d;

  logic          run, fin;
  res_e          fin_code;
  act_e          step;
  ctl_t          ctl_w;
  logic [PW-1:0] pos_w, len_w;
  logic [IW-1:0] cur_w;

  always_comb begin
    busy_d = busy_q;  act_d = act_q;   cur_d = cur_q;   pos_d = pos_q;
    len_d  = len_q;   num_d = num_q;   exp_d = exp_q;   ctl_d = ctl_q;
    res_d  = res_q;   wdat_d = wdat_q; rxd_d = rxd_q;   rxp_d = rxp_q;
    rxm_d  = rxm_q;
    done_d = 1'b0;  wr_d = 1'b0;  rd_d = 1'b0;  rxv_d = 1'b0;
    run = 1'b0;  fin = 1'b0;  fin_code = RES_OK;  step = act_q;
    ctl_w = ctl_q;  pos_w = pos_q;  len_w = len_q;  cur_w = cur_q;

    if (!busy_q) begin
      if (go) begin
        run    = 1'b1;
        step   = ACT_START;
        busy_d = 1'b1;
        num_d  = num_msgs;
        ctl_w  = CTL_IDLE_EN;
        pos_w  = '0;
        cur_w  = '0;
      end
    end else if (evt) begin
      if (fault) begin
        fin      = 1'b1;
        fin_code = fault_code;
      end else begin
        run   = 1'b1;
        exp_d = 1'b0;
      end
    end

    if (run) begin
      ctl_w.rstart = 1'b0;
      ctl_w.tx     = 1'b0;
      ctl_w.nak    = 1'b0;
      case (step)
        ACT_START, ACT_RESTART: begin
          ctl_w.rstart = (step == ACT_RESTART);
          ctl_w.master = 1'b1;
          ctl_w.tx     = 1'b1;
          wr_d   = 1'b1;
          wdat_d = {d_addr, d_rd};
          exp_d  = 1'b1;
          len_w  = PW'(d_len);
          act_d  = d_rd ? ACT_RD_BEGIN : ACT_WRITE;
        end
        ACT_RD_BEGIN: begin
          if (len_w != '0) begin
            if (len_w == PW'(1) && !d_blk) ctl_w.nak = 1'b1;
            rd_d = 1'b1;
          end
          act_d = ACT_RD_BYTE;
        end
        ACT_RD_BYTE: begin
          if (pos_w != '0 || !d_blk) begin
            if (pos_w + PW'(2) == len_w) ctl_w.nak = 1'b1;
            if (pos_w + PW'(1) == len_w) ctl_w.tx  = 1'b1;
          end
          rd_d  = 1'b1;
          rxv_d = 1'b1;
          rxd_d = rx_in;
          rxp_d = pos_w;
          rxm_d = cur_w;
          if (pos_w == '0 && d_blk) begin
            if (rx_in == 8'd0 || 32'(rx_in) > BLK_MAX) begin
              fin      = 1'b1;
              fin_code = RES_PROTO;
            end else begin
              len_w = len_w + PW'(rx_in);
              if (len_w == PW'(2)) ctl_w.nak = 1'b1;
            end
          end
          pos_w = pos_w + PW'(1);
        end
        ACT_WRITE: begin
          wr_d   = 1'b1;
          wdat_d = tx_byte;
          exp_d  = 1'b1;
          pos_w  = pos_w + PW'(1);
        end
        ACT_STOP: begin
          fin      = 1'b1;
          fin_code = RES_OK;
        end
        default: begin
          fin      = 1'b1;
          fin_code = RES_IO;
        end
      endcase

      if (!fin && step != ACT_STOP && pos_w == len_w) begin
        pos_w = '0;
        if (NW'(cur_w) + NW'(1) >= num_q || (!busy_q && NW'(1) >= num_msgs)) begin
          act_d = ACT_STOP;
          if (d_rd) begin
            fin      = 1'b1;
            fin_code = RES_OK;
          end
        end else begin
          cur_w = cur_w + IW'(1);
          act_d = ACT_RESTART;
        end
      end

      pos_d = pos_w;
      len_d = len_w;
      cur_d = cur_w;
      ctl_d = ctl_w;
    end

    if (fin) begin
      res_d  = fin_code;
      busy_d = 1'b0;
      done_d = 1'b1;
      ctl_d  = CTL_IDLE_EN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;     act_q <= ACT_STOP;  cur_q <= '0;   pos_q <= '0;
      len_q  <= '0;       num_q <= '0;        exp_q <= 1'b0; ctl_q <= '0;
      res_q  <= RES_OK;   done_q <= 1'b0;     wr_q <= 1'b0;  wdat_q <= '0;
      rd_q   <= 1'b0;     rxv_q <= 1'b0;      rxd_q <= '0;   rxp_q <= '0;
      rxm_q  <= '0;
    end else begin
      busy_q <= busy_d;   act_q <= act_d;     cur_q <= cur_d; pos_q <= pos_d;
      len_q  <= len_d;    num_q <= num_d;     exp_q <= exp_d; ctl_q <= ctl_d;
      res_q  <= res_d;    done_q <= done_d;   wr_q <= wr_d;   wdat_q <= wdat_d;
      rd_q   <= rd_d;     rxv_q <= rxv_d;     rxd_q <= rxd_d; rxp_q <= rxp_d;
      rxm_q  <= rxm_d;
    end
  end

  assign cur_idx    = busy_q ? cur_q : '0;
  assign expect_ack = exp_q;
  assign busy       = busy_q;
  assign done       = done_q;
  assign result     = res_q;
  assign ctl        = ctl_q;
  assign wr_valid   = wr_q;
  assign wr_data    = wdat_q;
  assign rd_req     = rd_q;
  assign rx_valid   = rxv_q;
  assign rx_msg     = rxm_q;
  assign rx_pos     = rxp_q;
  assign rx_data    = rxd_q;
  assign tx_pos     = pos_q;

  AST_START_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> wr_q && ctl_q.master && ctl_q.tx && ctl_q.en); // R1
  AST_RSTART_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_q.rstart) |-> wr_q && ctl_q.tx && ctl_q.master); // R2
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_q && rd_q)); // R3
  AST_FINISH_CTL: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q && ctl_q == CTL_IDLE_EN); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !go) |=> !wr_q && !rd_q && !done_q && $stable(res_q)); // R10

endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
  import i2c_seq_pkg::*;
#(
  parameter int N       = 4,
  parameter int AW      = 7,
  parameter int LW      = 8,
  parameter int BLK_MAX = 32,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int NW = $clog2(N + 1),
  localparam int PW = LW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          desc_we,
  input  logic [IW-1:0] desc_idx,
  input  logic [AW-1:0] desc_addr,
  input  logic          desc_rd,
  input  logic          desc_blk,
  input  logic [LW-1:0] desc_len,
  input  logic [NW-1:0] num_msgs,
  input  logic          go,
  output logic          busy,
  output logic          done,
  output logic [2:0]    result,
  output logic          ctl_en,
  output logic          ctl_master,
  output logic          ctl_tx,
  output logic          ctl_nak,
  output logic          ctl_rstart,
  output logic          eng_wr_valid,
  output logic [7:0]    eng_wr_data,
  output logic          eng_rd_req,
  input  logic          eng_evt,
  input  logic          eng_complete,
  input  logic          eng_arb_lost,
  input  logic          eng_rx_nak,
  input  logic [7:0]    eng_rx_data,
  output logic [IW-1:0] tx_msg,
  output logic [PW-1:0] tx_pos,
  input  logic [7:0]    tx_byte,
  output logic          rx_valid,
  output logic [IW-1:0] rx_msg,
  output logic [PW-1:0] rx_pos,
  output logic [7:0]    rx_data
);

  logic [IW-1:0] cur_idx;
  logic [AW-1:0] d_addr;
  logic          d_rd, d_blk;
  logic [LW-1:0] d_len;
  logic          exp_ack, fault;
  res_e          fault_code;
  ctl_t          ctl;

  i2c_seq_desc #(.N(N), .AW(AW), .LW(LW)) u_desc (
    .clk(clk), .rst_n(rst_n), .we(desc_we), .widx(desc_idx), .waddr(desc_addr),
    .wrd(desc_rd), .wblk(desc_blk), .wlen(desc_len), .ridx(cur_idx),
    .raddr(d_addr), .rrd(d_rd), .rblk(d_blk), .rlen(d_len)
  );

  i2c_seq_evt_chk u_chk (
    .complete(eng_complete), .arb_lost(eng_arb_lost), .rx_nak(eng_rx_nak),
    .expect_ack(exp_ack), .fault(fault), .code(fault_code)
  );

  i2c_seq_core #(.N(N), .AW(AW), .LW(LW), .BLK_MAX(BLK_MAX)) u_core (
    .clk(clk), .rst_n(rst_n), .go(go), .num_msgs(num_msgs),
    .d_addr(d_addr), .d_rd(d_rd), .d_blk(d_blk), .d_len(d_len),
    .evt(eng_evt), .fault(fault), .fault_code(fault_code),
    .rx_in(eng_rx_data), .tx_byte(tx_byte), .cur_idx(cur_idx),
    .expect_ack(exp_ack), .busy(busy), .done(done), .result(result), .ctl(ctl),
    .wr_valid(eng_wr_valid), .wr_data(eng_wr_data), .rd_req(eng_rd_req),
    .rx_valid(rx_valid), .rx_msg(rx_msg), .rx_pos(rx_pos), .rx_data(rx_data),
    .tx_pos(tx_pos)
  );

  assign tx_msg     = cur_idx;
  assign ctl_en     = ctl.en;
  assign ctl_master = ctl.master;
  assign ctl_tx     = ctl.tx;
  assign ctl_nak    = ctl.nak;
  assign ctl_rstart = ctl.rstart;

endmodule

// File: tb/i2c_xfer_seq_test.sv
module i2c_xfer_seq_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       desc_we = 1'b0;
  logic [1:0] desc_idx = '0;
  logic [6:0] desc_addr = '0;
  logic       desc_rd = 1'b0, desc_blk = 1'b0;
  logic [7:0] desc_len = '0;
  logic [2:0] num_msgs = 3'd1;
  logic       go = 1'b0;
  logic       eng_evt = 1'b0, eng_complete = 1'b0, eng_arb_lost = 1'b0, eng_rx_nak = 1'b0;
  logic [7:0] eng_rx_data = '0;
  logic       busy, done, ctl_en, ctl_master, ctl_tx, ctl_nak, ctl_rstart;
  logic [2:0] result;
  logic       eng_wr_valid, eng_rd_req, rx_valid;
  logic [7:0] eng_wr_data, rx_data, tx_byte;
  logic [1:0] tx_msg, rx_msg;
  logic [8:0] tx_pos, rx_pos;

  int n_chk = 0;
  int n_fail = 0;

  always #10ns clk = ~clk;

  assign tx_byte = 8'h30 + {2'b00, tx_msg, 4'h0} + tx_pos[7:0];

  i2c_xfer_seq uut (
    .clk(clk), .rst_n(rst_n), .desc_we(desc_we), .desc_idx(desc_idx),
    .desc_addr(desc_addr), .desc_rd(desc_rd), .desc_blk(desc_blk), .desc_len(desc_len),
    .num_msgs(num_msgs), .go(go), .busy(busy), .done(done), .result(result),
    .ctl_en(ctl_en), .ctl_master(ctl_master), .ctl_tx(ctl_tx), .ctl_nak(ctl_nak),
    .ctl_rstart(ctl_rstart), .eng_wr_valid(eng_wr_valid), .eng_wr_data(eng_wr_data),
    .eng_rd_req(eng_rd_req), .eng_evt(eng_evt), .eng_complete(eng_complete),
    .eng_arb_lost(eng_arb_lost), .eng_rx_nak(eng_rx_nak), .eng_rx_data(eng_rx_data),
    .tx_msg(tx_msg), .tx_pos(tx_pos), .tx_byte(tx_byte), .rx_valid(rx_valid),
    .rx_msg(rx_msg), .rx_pos(rx_pos), .rx_data(rx_data)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic setd(input int idx, input int addr, input bit rd, input bit blk, input int len);
    desc_we = 1'b1; desc_idx = 2'(idx); desc_addr = 7'(addr);
    desc_rd = rd; desc_blk = blk; desc_len = 8'(len);
    @(negedge clk);
    desc_we = 1'b0;
  endtask

  task automatic kick(input int n);
    num_msgs = 3'(n); go = 1'b1;
    @(negedge clk);
    go = 1'b0;
  endtask

  task automatic ev(input bit cmp, input bit arb, input bit nak, input int data);
    eng_evt = 1'b1; eng_complete = cmp; eng_arb_lost = arb; eng_rx_nak = nak;
    eng_rx_data = 8'(data);
    @(negedge clk);
    eng_evt = 1'b0; eng_complete = 1'b0; eng_arb_lost = 1'b0; eng_rx_nak = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset busy", busy, 0);
    chk("R1 reset done", done, 0);
    chk("R1 reset ctl", {ctl_en, ctl_master, ctl_tx, ctl_nak, ctl_rstart}, 0);
  endtask

  task automatic t_write();
    setd(0, 7'h50, 0, 0, 2);
    kick(1);
    chk("R1 addr strobe", eng_wr_valid, 1);
    chk("R1 addr byte", eng_wr_data, 8'hA0);
    chk("R1 ctl after go", {ctl_en, ctl_master, ctl_tx, ctl_nak, ctl_rstart}, 5'b11100);
    chk("R1 busy", busy, 1);
    kick(1);
    chk("R1 go while busy ignored", eng_wr_valid, 0);
    ev(1, 0, 0, 0);
    chk("R3 data0 strobe", eng_wr_valid, 1);
    chk("R3 data0", eng_wr_data, 8'h30);
    ev(1, 0, 0, 0);
    chk("R3 data1", eng_wr_data, 8'h31);
    chk("R8 no finish yet", done, 0);
    ev(1, 0, 0, 0);
    chk("R8 write stop done", done, 1);
    chk("R8 write result", result, 0);
    chk("R9 ctl only enable", {ctl_en, ctl_master, ctl_tx, ctl_nak, ctl_rstart}, 5'b10000);
    chk("R9 busy clear", busy, 0);
    @(negedge clk);
    chk("R9 done one cycle", done, 0);
  endtask

  task automatic t_nodev();
    setd(0, 7'h50, 0, 0, 2);
    kick(1);
    ev(1, 0, 1, 0);
    chk("R3 addr nak result", result, 3);
    chk("R3 addr nak done", done, 1);
    kick(1);
    ev(1, 0, 0, 0);
    ev(1, 0, 1, 0);
    chk("R3 data nak result", result, 3);
  endtask

  task automatic t_priority();
    setd(0, 7'h50, 0, 0, 2);
    kick(1);
    ev(0, 1, 1, 0);
    chk("R7 incomplete first", result, 1);
    kick(1);
    ev(1, 1, 1, 0);
    chk("R7 arb before nak", result, 2);
    chk("R7 done", done, 1);
  endtask

  task automatic t_read1();
    setd(0, 7'h48, 1, 0, 1);
    kick(1);
    chk("R1 read addr byte", eng_wr_data, 8'h91);
    ev(1, 0, 0, 0);
    chk("R4 dummy read", eng_rd_req, 1);
    chk("R4 nak len1", ctl_nak, 1);
    ev(1, 0, 1, 8'h5C);
    chk("R8 read byte", rx_data, 8'h5C);
    chk("R8 rx strobe", rx_valid, 1);
    chk("R8 read finish now", done, 1);
    chk("R5 rx nak ignored", result, 0);
  endtask

  task automatic t_rd_wr();
    setd(0, 7'h21, 1, 0, 3);
    setd(1, 7'h22, 0, 0, 1);
    kick(2);
    chk("R1 msg0 addr", eng_wr_data, 8'h43);
    ev(1, 0, 0, 0);
    chk("R4 dummy read len3", eng_rd_req, 1);
    chk("R4 no nak len3", ctl_nak, 0);
    ev(1, 0, 1, 8'h11);
    chk("R5 pos0 data", rx_data, 8'h11);
    chk("R5 pos0 ctl", {ctl_tx, ctl_nak}, 2'b00);
    ev(1, 0, 0, 8'h12);
    chk("R5 pos1 pos", rx_pos, 1);
    chk("R5 pos1 nak", {ctl_tx, ctl_nak}, 2'b01);
    ev(1, 0, 0, 8'h13);
    chk("R5 pos2 tx", {ctl_tx, ctl_nak}, 2'b10);
    chk("R5 no finish mid", done, 0);
    ev(1, 0, 0, 0);
    chk("R2 restart", {ctl_master, ctl_tx, ctl_rstart}, 3'b111);
    chk("R2 msg1 addr", eng_wr_data, 8'h44);
    chk("R2 addr strobe", eng_wr_valid, 1);
    ev(1, 0, 0, 0);
    chk("R3 msg1 data", eng_wr_data, 8'h40);
    chk("R2 restart cleared", ctl_rstart, 0);
    ev(1, 0, 0, 0);
    chk("R8 two msg done", done, 1);
    chk("R8 two msg result", result, 0);
  endtask

  task automatic t_block();
    setd(0, 7'h10, 1, 1, 1);
    kick(1);
    ev(1, 0, 0, 0);
    chk("R4 block no early nak", ctl_nak, 0);
    chk("R4 block dummy read", eng_rd_req, 1);
    ev(1, 0, 0, 0);
    chk("R6 count zero", result, 4);
    chk("R6 count zero done", done, 1);
    kick(1); ev(1, 0, 0, 0); ev(1, 0, 0, 33);
    chk("R6 count 33", result, 4);
    kick(1); ev(1, 0, 0, 0); ev(1, 0, 0, 1);
    chk("R6 count1 nak now", ctl_nak, 1);
    chk("R6 count1 busy", busy, 1);
    ev(1, 0, 0, 8'h77);
    chk("R6 count1 data pos", rx_pos, 1);
    chk("R6 count1 finish", done, 1);
    chk("R6 count1 ok", result, 0);
    kick(1); ev(1, 0, 0, 0); ev(1, 0, 0, 2);
    chk("R6 count2 no nak", ctl_nak, 0);
    ev(1, 0, 0, 8'h01);
    chk("R6 count2 nak pos1", ctl_nak, 1);
    ev(1, 0, 0, 8'h02);
    chk("R6 count2 finish", done, 1);
  endtask

  task automatic t_idle();
    setd(0, 7'h50, 0, 0, 1);
    kick(1);
    ev(1, 0, 1, 0);
    chk("R10 setup result", result, 3);
    ev(1, 0, 0, 0);
    chk("R10 idle no write", eng_wr_valid, 0);
    chk("R10 idle no read", eng_rd_req, 0);
    chk("R10 idle no done", done, 0);
    chk("R10 idle result kept", result, 3);
    chk("R10 idle ctl kept", {ctl_en, ctl_master, ctl_tx, ctl_nak, ctl_rstart}, 5'b10000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write();
    t_nodev();
    t_priority();
    t_read1();
    t_rd_wr();
    t_block();
    t_idle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2ms;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule